// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

The block is a first-in first-out buffer for 18-bit words. One clock domain writes it and another reads it, and the two clocks have no fixed relation. Either clock may run faster, and a read and a write may happen in the same cycle. Gray-coded pointers cross between the domains through two-stage synchronizers. Each domain computes its own flags, so every flag is valid in the clock of the logic that uses it.

A mode input is captured during master reset and selects one of two read timings. In the registered-read timing, a read enable is needed to move a word onto the output, and the status pins report empty and full. In the fall-through timing, the oldest word is placed on the output without any request, and the status pins report output-valid and room-available.

The almost-empty and almost-full thresholds start at one of two presets. A loader on the write side can replace them, either over the data bus or one bit at a time. There are two reset levels. A master reset clears everything. A partial reset clears only the stored data and keeps the thresholds and the mode. A retransmit request rewinds reading to the first word written since the last reset.

Top module: `dcfifo_flags`

## Requirements
- R1: Words come out in the order they were written, with all 18 bits kept. In registered-read mode, a read enable sampled while data is present puts the next word on `dout` at that same read-clock edge. With no read enable, `dout` holds its value.
- R2: In registered-read mode, `stat_wr` is 1 when DEPTH words are stored. A write attempted while the FIFO is full is dropped and never appears at the output.
- R3: In registered-read mode, `stat_rd` is 1 when no word is stored. A read while empty leaves `dout` unchanged and does not move the read position, so the next word written is the next word read.
- R4: `hf` is 1 exactly when the number of stored words is greater than DEPTH/2.
- R5: `ae` is 1 when the stored word count is at most the empty threshold. `af` is 1 when the count is at least DEPTH minus the full threshold. After master reset both thresholds equal 7 if `preset_sel` is 0, and 63 if `preset_sel` is 1.
- R6: Parallel threshold load: a write-clock cycle with `ld` and `wen` both high copies `din[AW-1:0]` into a threshold and does not store the word. Successive loads alternate between the empty threshold and the full threshold, and the first load after either reset goes to the empty threshold.
- R7: Serial threshold load: each write-clock cycle with `ld` and `sen` both high takes `si` as the next bit. The first AW pulses fill the empty threshold, least significant bit first. The next AW pulses fill the full threshold in the same bit order.
- R8: Master reset empties the FIFO, restores both thresholds to the preset chosen by `preset_sel`, and captures `fwft_sel` as the read mode: 0 selects registered-read, 1 selects fall-through.
- R9: Partial reset empties the FIFO and keeps both thresholds and the read mode.
- R10: A one-cycle `rt` pulse rewinds reading to the first word written since reset. In registered-read mode, the next read enable returns that word. In fall-through mode, that word is on `dout` with `stat_rd` at 1 after the second read-clock edge counted from the edge that sampled `rt`.
- R11: In fall-through mode, `stat_rd` is 1 while a valid word is on `dout`, and `stat_wr` is 1 while a write would be accepted. The first word written appears on `dout` with no read enable. A read enable removes the presented word. The FIFO holds DEPTH+1 words: the memory plus the output register.
- R12: While `oe` is 0, `dout` is all zeros. While `oe` is 1, `dout` carries the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wen | input | 1 | Write enable; with `ld` high it loads a threshold instead of writing |
| din | input | 18 | Write data; the low AW bits carry a parallel threshold value |
| ld | input | 1 | Threshold load qualifier (write domain) |
| sen | input | 1 | Serial load enable (write domain) |
| si | input | 1 | Serial load data bit |
| rclk | input | 1 | Read clock |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit request (read domain) |
| oe | input | 1 | Output enable for `dout` |
| dout | output | 18 | Read data |
| mrst | input | 1 | Master reset, active high, held across several edges of both clocks |
| prst | input | 1 | Partial reset, active high, held across several edges of both clocks |
| fwft_sel | input | 1 | Read mode captured during master reset (1 = fall-through) |
| preset_sel | input | 1 | Threshold preset captured during master reset (0 = 7, 1 = 63) |
| stat_rd | output | 1 | Empty in registered-read mode, output-valid in fall-through mode |
| stat_wr | output | 1 | Full in registered-read mode, room-available in fall-through mode |
| hf | output | 1 | More than half full |
| ae | output | 1 | Almost empty |
| af | output | 1 | Almost full |

## Verification
The assertions assume several things about the environment. Each reset is held for at least two edges of each clock. `fwft_sel` and `preset_sel` stay steady while master reset is high. The thresholds are loaded only while the read side is idle, because the read domain uses the empty threshold without a synchronizer. A retransmit is requested only when no more than DEPTH words have been written since the last reset.

The stimulus stays within these limits. It drives write-side inputs on write-clock falling edges and read-side inputs on read-clock falling edges, and it holds every reset for six read-clock cycles. It loads thresholds only before any data is stored and issues retransmits only after a few words have been written. The bench also waits for both synchronizers to settle before it checks a flag computed in the other domain.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    // Read timing captured during master reset
    typedef enum logic {
        MODE_REG  = 1'b0,
        MODE_FALL = 1'b1
    } rd_mode_e;

    // The two threshold presets a master reset can choose from
    localparam int PRESET_LO = 7;
    localparam int PRESET_HI = 63;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st1_d, st1_q, st2_d, st2_q;

    always_comb begin
        st1_d = rst ? '0 : d;
        st2_d = rst ? '0 : st1_q;
    end

    always_ff @(posedge clk) begin
        st1_q <= st1_d;
        st2_q <= st2_d;
    end

    assign q = st2_q;
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          wen,
    input  logic          ld,
    input  logic          sen,
    input  logic          si,
    input  logic [AW-1:0] ofs_din,
    input  logic          preset_sel,
    input  logic          mode_sel,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          hf,
    output logic          af,
    output logic [AW-1:0] ae_off,
    output logic          mode
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int SW    = $clog2(2 * AW);
    localparam logic [PW-1:0] DEPTH_V  = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_V   = PW'(DEPTH / 2);
    localparam logic [SW-1:0] SER_LAST = SW'(2 * AW - 1);
    localparam logic [AW-1:0] PRE_LO   = AW'(PRESET_LO);
    localparam logic [AW-1:0] PRE_HI   = AW'(PRESET_HI);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [AW-1:0] ae_off;
        logic [AW-1:0] af_off;
        logic          par_af;   // next parallel load targets the full threshold
        logic [SW-1:0] ser_idx;  // next serial bit position across both thresholds
        logic          mode;
    } wst_t;

    wst_t          s_q, s_d;
    logic [PW-1:0] rbin, wcount, af_thr;
    logic          full_i, do_wr, in_rst;

    always_comb begin
        in_rst = mrst || prst;
        rbin   = PW'(from_gray(32'(rgray_s)));
        wcount = s_q.wptr - rbin;
        full_i = (wcount == DEPTH_V);
        do_wr  = wen && !ld && !full_i && !in_rst;

        s_d = s_q;
        if (do_wr) s_d.wptr = s_q.wptr + 1'b1;

        if (!in_rst) begin
            if (ld && wen) begin
                if (s_q.par_af) s_d.af_off = ofs_din;
                else            s_d.ae_off = ofs_din;
                s_d.par_af = !s_q.par_af;
            end else if (ld && sen) begin
                for (int i = 0; i < AW; i++) begin
                    if (s_q.ser_idx == SW'(i))      s_d.ae_off[i] = si;
                    if (s_q.ser_idx == SW'(i + AW)) s_d.af_off[i] = si;
                end
                s_d.ser_idx = (s_q.ser_idx == SER_LAST) ? '0 : s_q.ser_idx + 1'b1;
            end
        end

        if (in_rst) begin
            s_d.wptr    = '0;
            s_d.par_af  = 1'b0;
            s_d.ser_idx = '0;
        end
        if (mrst) begin
            s_d.ae_off = preset_sel ? PRE_HI : PRE_LO;
            s_d.af_off = preset_sel ? PRE_HI : PRE_LO;
            s_d.mode   = mode_sel;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    always_comb begin
        af_thr = DEPTH_V - {1'b0, s_q.af_off};
        we     = do_wr;
        waddr  = s_q.wptr[AW-1:0];
        wgray  = PW'(to_gray(32'(s_q.wptr)));
        full   = full_i;
        hf     = (wcount > HALF_V);
        af     = (wcount >= af_thr);
        ae_off = s_q.ae_off;
        mode   = s_q.mode;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (mrst || prst) (full && wen && !ld) |=> $stable(s_q.wptr)) else $error("write accepted while full"); // R2
    AST_WCOUNT_BOUND: assert property (@(posedge clk) disable iff (mrst || prst) wcount <= DEPTH_V) else $error("write count beyond depth"); // R2
    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (mrst || prst) $onehot0(wgray ^ $past(wgray))) else $error("write gray pointer moved more than one bit"); // R1
    AST_OFFS_KEPT: assert property (@(posedge clk) disable iff (mrst) prst |=> ($stable(s_q.ae_off) && $stable(s_q.af_off))) else $error("thresholds lost on partial reset"); // R9
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          ren,
    input  logic          rt,
    input  logic          mode_sel,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_off,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          ae,
    output logic          ov,
    output logic          mode,
    output logic [DW-1:0] dout
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] rptr;
        logic [DW-1:0] dout;
        logic          ov;    // output register holds a word not yet consumed
        logic          mode;
    } rst_t;

    rst_t          s_q, s_d;
    logic [PW-1:0] wbin, rcount;
    logic          empty_i, fall, pop;

    always_comb begin
        wbin    = PW'(from_gray(32'(wgray_s)));
        rcount  = wbin - s_q.rptr;
        empty_i = (rcount == '0);
        fall    = (s_q.mode == MODE_FALL);
        pop     = !empty_i && (fall ? (!s_q.ov || ren) : ren);

        s_d = s_q;
        if (rt) begin
            s_d.rptr = '0;
            s_d.ov   = 1'b0;
        end else if (pop) begin
            s_d.dout = rdata;
            s_d.rptr = s_q.rptr + 1'b1;
            s_d.ov   = 1'b1;
        end else if (fall && ren) begin
            s_d.ov = 1'b0;
        end

        if (mrst || prst) begin
            s_d.rptr = '0;
            s_d.ov   = 1'b0;
            s_d.dout = '0;
        end
        if (mrst) s_d.mode = mode_sel;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    always_comb begin
        raddr = s_q.rptr[AW-1:0];
        rgray = PW'(to_gray(32'(s_q.rptr)));
        empty = empty_i;
        ae    = (rcount <= {1'b0, ae_off});
        ov    = s_q.ov;
        mode  = s_q.mode;
        dout  = s_q.dout;
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (mrst || prst) (empty_i && !rt) |=> $stable(s_q.rptr)) else $error("read pointer moved while empty"); // R3
    AST_RCOUNT_BOUND: assert property (@(posedge clk) disable iff (mrst || prst) rcount <= DEPTH_V) else $error("read count beyond depth"); // R3
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (mrst || prst) (!s_q.mode && !ren) |=> $stable(s_q.dout)) else $error("output changed without read enable"); // R1
    AST_FALL_HOLD: assert property (@(posedge clk) disable iff (mrst || prst) (s_q.mode && s_q.ov && !ren && !rt) |=> (s_q.ov && $stable(s_q.dout))) else $error("presented word lost without read"); // R11
    AST_RT_REWIND: assert property (@(posedge clk) disable iff (mrst || prst) rt |=> (s_q.rptr == '0 && !s_q.ov)) else $error("retransmit did not rewind"); // R10
    AST_MODE_KEPT: assert property (@(posedge clk) disable iff (mrst) $stable(s_q.mode)) else $error("read mode changed outside master reset"); // R9
endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/1ps
module dcfifo_flags #(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          wen,
    input  logic [DW-1:0] din,
    input  logic          ld,
    input  logic          sen,
    input  logic          si,
    input  logic          rclk,
    input  logic          ren,
    input  logic          rt,
    input  logic          oe,
    output logic [DW-1:0] dout,
    input  logic          mrst,
    input  logic          prst,
    input  logic          fwft_sel,
    input  logic          preset_sel,
    output logic          stat_rd,
    output logic          stat_wr,
    output logic          hf,
    output logic          ae,
    output logic          af
);
    localparam int PW = AW + 1;

    logic          we, full, empty, ov, mode_w, mode_r, any_rst;
    logic [AW-1:0] waddr, raddr, ae_off;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [DW-1:0] rdata, dout_i;

    assign any_rst = mrst || prst;

    dcf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    dcf_sync #(.W(PW)) u_sync_w2r (
        .clk (rclk),
        .rst (any_rst),
        .d   (wgray),
        .q   (wgray_s)
    );

    dcf_sync #(.W(PW)) u_sync_r2w (
        .clk (wclk),
        .rst (any_rst),
        .d   (rgray),
        .q   (rgray_s)
    );

    dcf_wr_ctrl #(.AW(AW)) u_wr (
        .clk        (wclk),
        .mrst       (mrst),
        .prst       (prst),
        .wen        (wen),
        .ld         (ld),
        .sen        (sen),
        .si         (si),
        .ofs_din    (din[AW-1:0]),
        .preset_sel (preset_sel),
        .mode_sel   (fwft_sel),
        .rgray_s    (rgray_s),
        .we         (we),
        .waddr      (waddr),
        .wgray      (wgray),
        .full       (full),
        .hf         (hf),
        .af         (af),
        .ae_off     (ae_off),
        .mode       (mode_w)
    );

    dcf_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
        .clk      (rclk),
        .mrst     (mrst),
        .prst     (prst),
        .ren      (ren),
        .rt       (rt),
        .mode_sel (fwft_sel),
        .wgray_s  (wgray_s),
        .ae_off   (ae_off),
        .rdata    (rdata),
        .raddr    (raddr),
        .rgray    (rgray),
        .empty    (empty),
        .ae       (ae),
        .ov       (ov),
        .mode     (mode_r),
        .dout     (dout_i)
    );

    assign stat_wr = mode_w ? !full : full;
    assign stat_rd = mode_r ? ov : empty;
    assign dout    = oe ? dout_i : '0;
endmodule

// File: tb/tb_dcfifo_flags.sv
`timescale 1ns/1ps
module tb_dcfifo_flags;
    localparam int DW = 18;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic wclk = 1'b0, rclk = 1'b0;
    logic wen = 0, ld = 0, sen = 0, si = 0, ren = 0, rt = 0, oe = 1;
    logic mrst = 0, prst = 0, fwft_sel = 0, preset_sel = 0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic stat_rd, stat_wr, hf, ae, af;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 wclk = ~wclk;   // 200 MHz write clock
    always #3.5 rclk = ~rclk;   // unrelated read clock

    dcfifo_flags #(.DW(DW), .AW(AW)) dut (
        .wclk(wclk), .wen(wen), .din(din), .ld(ld), .sen(sen), .si(si),
        .rclk(rclk), .ren(ren), .rt(rt), .oe(oe), .dout(dout),
        .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel), .preset_sel(preset_sel),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .hf(hf), .ae(ae), .af(af)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic do_reset(bit master, bit fw, bit pre);
        @(negedge rclk);
        fwft_sel = fw; preset_sel = pre;
        if (master) mrst = 1; else prst = 1;
        repeat (6) @(negedge rclk);
        mrst = 0; prst = 0;
        settle();
    endtask

    task automatic wr(logic [DW-1:0] d);
        @(negedge wclk); wen = 1; din = d;
        @(negedge wclk); wen = 0;
    endtask

    task automatic fill(int n, logic [DW-1:0] base);
        for (int i = 0; i < n; i++) wr(base + DW'(i));
    endtask

    task automatic rd();
        @(negedge rclk); ren = 1;
        @(negedge rclk); ren = 0;
    endtask

    task automatic pulse_rt();
        @(negedge rclk); rt = 1;
        @(negedge rclk); rt = 0;
    endtask

    task automatic par_load(logic [AW-1:0] v);
        @(negedge wclk); ld = 1; wen = 1; din = DW'(v);
        @(negedge wclk); ld = 0; wen = 0;
    endtask

    task automatic ser_load(logic [AW-1:0] ae_v, logic [AW-1:0] af_v);
        for (int i = 0; i < 2 * AW; i++) begin
            @(negedge wclk); ld = 1; sen = 1;
            si = (i < AW) ? ae_v[i] : af_v[i - AW];
        end
        @(negedge wclk); ld = 0; sen = 0; si = 0;
    endtask

    task automatic t_reset_state();
        do_reset(1, 0, 0);
        check("R8 reset stat_rd empty", stat_rd, 1);
        check("R8 reset stat_wr not full", stat_wr, 0);
        check("R4 reset hf", hf, 0);
        check("R5 reset ae", ae, 1);
        check("R5 reset af", af, 0);
        check("R8 reset dout", dout, 0);
    endtask

    task automatic t_order();
        do_reset(1, 0, 0);
        fill(5, 18'h2A5A0);
        settle();
        check("R3 not empty after writes", stat_rd, 0);
        check("R1 no read yet, dout held", dout, 0);
        for (int i = 0; i < 5; i++) begin
            rd();
            check("R1 order", dout, 18'h2A5A0 + i);
        end
    endtask

    task automatic t_thresholds();
        do_reset(1, 0, 0);
        fill(7, 18'h100);  settle(); check("R5 ae at 7 words", ae, 1);
        fill(1, 18'h107);  settle(); check("R5 ae at 8 words", ae, 0);
        fill(120, 18'h108);          check("R4 hf at 128 words", hf, 0);
        fill(1, 18'h180);            check("R4 hf at 129 words", hf, 1);
        fill(119, 18'h181);          check("R5 af at 248 words", af, 0);
        fill(1, 18'h1F8);            check("R5 af at 249 words", af, 1);
        fill(6, 18'h1F9);            check("R2 not full at 255", stat_wr, 0);
        fill(1, 18'h1FF);            check("R2 full at 256", stat_wr, 1);
        wr(18'h3FFFF);               // dropped
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            rd();
            check("R2 R1 drain order", dout, 18'h100 + i);
        end
        settle();
        check("R3 empty after drain", stat_rd, 1);
        rd();
        check("R3 read while empty keeps dout", dout, 18'h1FF);
        wr(18'h2AAAA);
        settle();
        rd();
        check("R3 R2 next word after empty read", dout, 18'h2AAAA);
    endtask

    task automatic t_preset_hi();
        do_reset(1, 0, 1);
        fill(63, 18'h0); settle(); check("R5 R8 ae at 63 (preset 63)", ae, 1);
        fill(1, 18'h0);  settle(); check("R5 R8 ae at 64 (preset 63)", ae, 0);
        fill(128, 18'h0);          check("R5 af at 192 (preset 63)", af, 0);
        fill(1, 18'h0);            check("R5 af at 193 (preset 63)", af, 1);
    endtask

    task automatic t_parallel_and_partial();
        do_reset(1, 0, 0);
        par_load(8'd10);
        par_load(8'd20);
        settle();
        check("R6 load words not stored", stat_rd, 1);
        fill(10, 18'h0);  settle(); check("R6 ae at 10", ae, 1);
        fill(1, 18'h0);   settle(); check("R6 ae at 11", ae, 0);
        fill(224, 18'h0);           check("R6 af at 235", af, 0);
        fill(1, 18'h0);             check("R6 af at 236", af, 1);
        do_reset(0, 0, 1);
        check("R9 partial reset empties", stat_rd, 1);
        check("R9 partial reset clears af", af, 0);
        check("R9 partial reset clears hf", hf, 0);
        fill(10, 18'h0);  settle(); check("R9 ae threshold kept at 10", ae, 1);
        fill(1, 18'h0);   settle(); check("R9 ae threshold kept at 11", ae, 0);
        check("R9 registered mode kept, no fall-through", dout, 0);
        do_reset(1, 0, 0);
        fill(7, 18'h0);   settle(); check("R8 ae preset restored at 7", ae, 1);
        fill(1, 18'h0);   settle(); check("R8 ae preset restored at 8", ae, 0);
    endtask

    task automatic t_serial();
        do_reset(1, 0, 0);
        ser_load(8'd5, 8'd100);
        settle();
        check("R7 serial load stores nothing", stat_rd, 1);
        fill(5, 18'h0);   settle(); check("R7 ae at 5", ae, 1);
        fill(1, 18'h0);   settle(); check("R7 ae at 6", ae, 0);
        fill(149, 18'h0);           check("R7 af at 155", af, 0);
        fill(1, 18'h0);             check("R7 af at 156", af, 1);
    endtask

    task automatic t_retransmit_reg();
        do_reset(1, 0, 0);
        fill(4, 18'h15000);
        settle();
        rd(); check("R10 first read", dout, 18'h15000);
        rd(); check("R10 second read", dout, 18'h15001);
        pulse_rt();
        rd(); check("R10 reread word 0", dout, 18'h15000);
        rd(); check("R10 reread word 1", dout, 18'h15001);
    endtask

    task automatic t_fall_through();
        int acc;
        do_reset(1, 1, 0);
        check("R11 fall mode empty: not ready", stat_rd, 0);
        check("R11 fall mode: input ready", stat_wr, 1);
        wr(18'h0ABCD);
        settle();
        check("R11 first word without read", dout, 18'h0ABCD);
        check("R11 output ready", stat_rd, 1);
        wr(18'h0BBBB); wr(18'h0CCCC);
        settle();
        rd(); check("R11 pop to second", dout, 18'h0BBBB);
        rd(); check("R11 pop to third", dout, 18'h0CCCC);
        rd(); check("R11 pop last clears ready", stat_rd, 0);
        settle();
        acc = 0;
        for (int i = 0; i < DEPTH + 8; i++) begin
            if (stat_wr !== 1'b1) break;
            wr(18'h20000 + DW'(i));
            acc++;
        end
        check("R11 capacity depth+1", acc, DEPTH + 1);
        settle();
        for (int i = 0; i < DEPTH + 1; i++) begin
            check("R11 fall-through order", dout, 18'h20000 + i);
            rd();
        end
        check("R11 ready low after last pop", stat_rd, 0);
    endtask

    task automatic t_retransmit_fall_and_oe();
        do_reset(0, 0, 0);   // partial: mode must stay fall-through
        check("R9 fall mode kept: input ready", stat_wr, 1);
        fill(4, 18'h31000);
        settle();
        check("R9 fall mode kept: word presented", dout, 18'h31000);
        rd(); rd();
        check("R10 fall before rewind", dout, 18'h31002);
        pulse_rt();
        @(negedge rclk);
        check("R10 fall rewind ready", stat_rd, 1);
        check("R10 fall rewind word 0", dout, 18'h31000);
        @(negedge rclk); oe = 0;
        @(negedge rclk);
        check("R12 oe low zeros", dout, 0);
        oe = 1;
        @(negedge rclk);
        check("R12 oe high data", dout, 18'h31000);
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_order();
        t_thresholds();
        t_preset_hi();
        t_parallel_and_partial();
        t_serial();
        t_retransmit_reg();
        t_fall_through();
        t_retransmit_fall_and_oe();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule